// File: doc/BRIEF.md
# Eye-Scan Measurement and Trigger Controller

This block is the control core of a receiver margin-analysis unit. Two flows share one state machine. The first is a bit-error-rate measurement that counts samples and masked errors over a fixed window. The second is a logic-analyzer-style flow that arms, waits for a selectable trigger, and then freezes snapshots of the data and error buses.

Every cycle the block takes one data word and one error word of `DATA_W` valid bits. A 6-bit control word starts and stops the flows and selects the trigger. The sample mask, the qualifier pattern and the qualifier mask are 80-bit vectors. In each of them, the current word sits in the top `DATA_W` bits of the low half and the previous word sits in the top `DATA_W` bits of the high half. The captures use the same layout.

The block reports a 4-bit status, made of a done flag and a 3-bit state code. It also reports the two counts and the two captures.

Top module: `eye_scan_ctrl`

## Requirements
- R1: `status_o[3:1]` carries the state code: idle 000, clear 001, count 011, end 010, armed 101, read 100. `status_o[0]` is 1 exactly when the code is idle, end or read.
- R2: In idle, `ctrl_i[0]` (run) moves the machine to clear and then to count. When run and `ctrl_i[1]` (arm) are both set, run wins.
- R3: In idle, arm alone moves the machine to clear and then to armed.
- R4: Clear lasts one cycle. On leaving it, both counts and both captures are zero.
- R5: In count, the sample count rises by 1 every cycle. The error count rises by 1 in any cycle where `sdata_i & ~sdata_mask_i[39 -: DATA_W]` is nonzero. Both counts saturate. The machine enters end on the edge where the sample count reaches its all-ones maximum.
- R6: In end and idle, both counts hold their final values.
- R7: Trigger select `ctrl_i[2]`: in armed, the machine fires on any unmasked error bit of the current word. A mask bit of 1 excludes that bit.
- R8: Trigger select `ctrl_i[3]`: in armed, the machine fires when the current and previous data words equal the qualifier in their slots, comparing only bits whose qualifier-mask bit is 0.
- R9: Trigger select `ctrl_i[4]` fires on `trig_i` high, and `ctrl_i[5]` fires at once. When several selects are set, any one of them fires.
- R10: In armed, a fire moves the machine to read. If nothing fires and arm is low, the machine moves to read without changing the captures.
- R11: On a fire, each capture holds the present word in bits `[39 -: DATA_W]` and the previous cycle's word in bits `[79 -: DATA_W]`. All other bits are 0. The captures stay stable in read.
- R12: From end or read, the machine returns to idle on the first edge where run and arm are both low. Otherwise it stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 6 | [0] run, [1] arm, [5:2] trigger select |
| rdata_i | input | DATA_W | Received data word |
| sdata_i | input | DATA_W | Error word |
| sdata_mask_i | input | 80 | Error mask, 1 excludes a bit |
| qual_i | input | 80 | Qualifier pattern |
| qual_mask_i | input | 80 | Qualifier mask, 1 ignores a bit |
| trig_i | input | 1 | External trigger |
| status_o | output | 4 | {state code, done} |
| es_rdata_o | output | 80 | Data capture |
| es_sdata_o | output | 80 | Error capture |
| err_cnt_o | output | CNT_W | Error count |
| smp_cnt_o | output | CNT_W | Sample count |

## Verification
The trigger table pairs each select with a stimulus that must fire and one that must not. The non-firing cases are a masked error bit, a qualifier mismatch on a compared bit, and errors under a data-only select. A design that ignores the masks or ORs the wrong source would fire early. A directed capture with distinct previous and present words catches swapped or misaligned slots. A window that ends one cycle off shows up as a sample count other than the all-ones value. A design that drops arm without a move to read, or that keeps stale captures across clear, leaves the wrong status or nonzero captures after an abort.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;
  localparam int CAP_W  = 80;
  localparam int HALF_W = CAP_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_CLEAR = 3'b001,
    ST_COUNT = 3'b011,
    ST_END   = 3'b010,
    ST_ARMED = 3'b101,
    ST_READ  = 3'b100
  } es_state_e;
endpackage

// File: rtl/es_word_match.sv
module es_word_match
  import eye_scan_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic [DATA_W-1:0] rdata_cur_i,
  input  logic [DATA_W-1:0] rdata_prev_i,
  input  logic [DATA_W-1:0] sdata_cur_i,
  input  logic [CAP_W-1:0]  sdata_mask_i,
  input  logic [CAP_W-1:0]  qual_i,
  input  logic [CAP_W-1:0]  qual_mask_i,
  output logic              err_hit_o,
  output logic              qual_hit_o
);
  localparam int CUR_HI  = HALF_W - 1;
  localparam int PREV_HI = CAP_W - 1;

  if (DATA_W != 16 && DATA_W != 20) begin : g_bad_width
    $error("es_word_match: DATA_W must be 16 or 20");
  end

  logic [DATA_W-1:0] err_bits, cur_diff, prev_diff;

  assign err_bits  = sdata_cur_i & ~sdata_mask_i[CUR_HI -: DATA_W];
  assign cur_diff  = (rdata_cur_i ^ qual_i[CUR_HI -: DATA_W]) & ~qual_mask_i[CUR_HI -: DATA_W];
  assign prev_diff = (rdata_prev_i ^ qual_i[PREV_HI -: DATA_W]) & ~qual_mask_i[PREV_HI -: DATA_W];

  assign err_hit_o  = |err_bits;
  assign qual_hit_o = ~|{cur_diff, prev_diff};

  // bits outside the valid slots carry no meaning
  logic unused_slot_bits;
  assign unused_slot_bits = ^{sdata_mask_i, qual_i, qual_mask_i};
endmodule

// File: rtl/es_counter.sv
module es_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clr_i)                       cnt_o <= '0;
    else if (en_i && inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/es_capture.sv
module es_capture
  import eye_scan_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] prev_o,
  output logic [CAP_W-1:0]  cap_o
);
  logic [CAP_W-1:0] snap;

  always_comb begin
    snap = '0;
    snap[CAP_W-1  -: DATA_W] = prev_o;
    snap[HALF_W-1 -: DATA_W] = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o <= '0;
      cap_o  <= '0;
    end else begin
      prev_o <= din_i;
      if (clr_i)      cap_o <= '0;
      else if (cap_i) cap_o <= snap;
    end
  end
endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
  import eye_scan_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] sdata_i,
  input  logic [79:0]       sdata_mask_i,
  input  logic [79:0]       qual_i,
  input  logic [79:0]       qual_mask_i,
  input  logic              trig_i,
  output logic [3:0]        status_o,
  output logic [79:0]       es_rdata_o,
  output logic [79:0]       es_sdata_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [CNT_W-1:0]  smp_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_SMP = {{(CNT_W-1){1'b1}}, 1'b0};

  es_state_e state_q, state_d;
  logic run, arm, err_hit, qual_hit, fire, clr, cap, cnt_en;
  logic [3:0] sel;
  logic [DATA_W-1:0] rdata_prev, sdata_prev;

  assign run = ctrl_i[0];
  assign arm = ctrl_i[1];
  assign sel = ctrl_i[5:2];

  es_word_match #(.DATA_W(DATA_W)) u_match (
    .rdata_cur_i (rdata_i),
    .rdata_prev_i(rdata_prev),
    .sdata_cur_i (sdata_i),
    .sdata_mask_i(sdata_mask_i),
    .qual_i      (qual_i),
    .qual_mask_i (qual_mask_i),
    .err_hit_o   (err_hit),
    .qual_hit_o  (qual_hit)
  );

  // select bit order: error, qualifier, external, immediate
  assign fire   = |(sel & {1'b1, trig_i, qual_hit, err_hit});
  assign clr    = (state_q == ST_CLEAR);
  assign cap    = (state_q == ST_ARMED) && fire;
  assign cnt_en = (state_q == ST_COUNT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (run || arm) state_d = ST_CLEAR;
      ST_CLEAR: state_d = run ? ST_COUNT : (arm ? ST_ARMED : ST_IDLE);
      ST_COUNT: if (smp_cnt_o == LAST_SMP) state_d = ST_END;
      ST_ARMED: if (fire || !arm) state_d = ST_READ;
      ST_END,
      ST_READ:  if (!run && !arm) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign status_o = {state_q, (state_q == ST_IDLE) || (state_q == ST_END) || (state_q == ST_READ)};

  es_counter #(.W(CNT_W)) u_smp_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .en_i  (cnt_en), .inc_i(1'b1), .cnt_o(smp_cnt_o)
  );

  es_counter #(.W(CNT_W)) u_err_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .en_i  (cnt_en), .inc_i(err_hit), .cnt_o(err_cnt_o)
  );

  es_capture #(.DATA_W(DATA_W)) u_cap_r (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .cap_i(cap),
    .din_i (rdata_i), .prev_o(rdata_prev), .cap_o(es_rdata_o)
  );

  es_capture #(.DATA_W(DATA_W)) u_cap_s (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .cap_i(cap),
    .din_i (sdata_i), .prev_o(sdata_prev), .cap_o(es_sdata_o)
  );

  logic unused_prev;
  assign unused_prev = ^sdata_prev;
endmodule

// File: rtl/eye_scan_ctrl_chk.sv
module eye_scan_ctrl_chk
  import eye_scan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [5:0]       ctrl_i,
  input logic [3:0]       status_o,
  input logic [79:0]      es_rdata_o,
  input logic [79:0]      es_sdata_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [CNT_W-1:0] smp_cnt_o
);
  logic [2:0] st;
  logic run, arm;
  assign st  = status_o[3:1];
  assign run = ctrl_i[0];
  assign arm = ctrl_i[1];

  p_done_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == (st == ST_IDLE || st == ST_END || st == ST_READ));

  p_legal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st != 3'b110 && st != 3'b111);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && run) |=> st == ST_CLEAR);

  p_clear_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CLEAR && run) |=> st == ST_COUNT);

  p_clear_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CLEAR && !run && arm) |=> st == ST_ARMED);

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CLEAR) |=> (st != ST_CLEAR && err_cnt_o == '0 && smp_cnt_o == '0
                          && es_rdata_o == '0 && es_sdata_o == '0));

  p_count_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_COUNT) |=> smp_cnt_o == $past(smp_cnt_o) + 1'b1);

  p_err_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o <= smp_cnt_o);

  p_end_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_END || st == ST_IDLE) |=> ($stable(err_cnt_o) && $stable(smp_cnt_o)));

  p_arm_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ARMED && !arm) |=> st == ST_READ);

  p_read_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_READ) |=> ($stable(es_rdata_o) && $stable(es_sdata_o)));

  p_leave_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_END || st == ST_READ) && !run && !arm) |=> st == ST_IDLE);

  p_stay_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_END || st == ST_READ) && (run || arm)) |=> st == $past(st));
endmodule

bind eye_scan_ctrl eye_scan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_i    (ctrl_i),
  .status_o  (status_o),
  .es_rdata_o(es_rdata_o),
  .es_sdata_o(es_sdata_o),
  .err_cnt_o (err_cnt_o),
  .smp_cnt_o (smp_cnt_o)
);

// File: tb/eye_scan_ctrl_tb_top.sv
module eye_scan_ctrl_tb_top;
  localparam int DW = 16;
  localparam int CW = 4;

  localparam logic [3:0] S_IDLE  = 4'b0001;
  localparam logic [3:0] S_CLEAR = 4'b0010;
  localparam logic [3:0] S_COUNT = 4'b0110;
  localparam logic [3:0] S_END   = 4'b0101;
  localparam logic [3:0] S_ARMED = 4'b1010;
  localparam logic [3:0] S_READ  = 4'b1001;

  // {sel[3:0], trig, sdata[15:0], rdata[15:0], fire}
  localparam int NV = 9;
  localparam logic [37:0] VECS [NV] = '{
    {4'b0001, 1'b0, 16'h0001, 16'h0000, 1'b0},  // R7 masked error bit
    {4'b0001, 1'b0, 16'h0002, 16'h0000, 1'b1},  // R7 unmasked error
    {4'b0010, 1'b0, 16'h0000, 16'hA5A5, 1'b1},  // R8 exact match
    {4'b0010, 1'b0, 16'h0000, 16'hA5A4, 1'b0},  // R8 compared bit differs
    {4'b0010, 1'b0, 16'h0000, 16'h25A5, 1'b1},  // R8 ignored bit differs
    {4'b0100, 1'b1, 16'h0000, 16'h0000, 1'b1},  // R9 external
    {4'b0100, 1'b0, 16'hFFFF, 16'h0000, 1'b0},  // R9 errors not selected
    {4'b1000, 1'b0, 16'h0000, 16'h0000, 1'b1},  // R9 immediate
    {4'b0011, 1'b0, 16'h0004, 16'h0000, 1'b1}   // R9 any of several
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] ctrl_i = '0;
  logic [DW-1:0] rdata_i = '0, sdata_i = '0;
  logic [79:0] sdata_mask_i, qual_i, qual_mask_i;
  logic trig_i = 1'b0;
  logic [3:0] status_o;
  logic [79:0] es_rdata_o, es_sdata_o;
  logic [CW-1:0] err_cnt_o, smp_cnt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  eye_scan_ctrl #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .rdata_i(rdata_i),
    .sdata_i(sdata_i), .sdata_mask_i(sdata_mask_i), .qual_i(qual_i),
    .qual_mask_i(qual_mask_i), .trig_i(trig_i), .status_o(status_o),
    .es_rdata_o(es_rdata_o), .es_sdata_o(es_sdata_o),
    .err_cnt_o(err_cnt_o), .smp_cnt_o(smp_cnt_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_st(input string tag, input logic [3:0] exp);
    chk(status_o == exp, tag, 80'(status_o), 80'(exp));
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    sdata_mask_i = 80'(1) << 24;
    qual_i       = 80'(16'hA5A5) << 24;
    qual_mask_i  = (80'(16'hFFFF) << 64) | (80'(1) << 39);

    step(2);
    rst_ni = 1'b1;
    step(1);
    chk_st("R1 reset status", S_IDLE);
    chk(err_cnt_o == 0 && smp_cnt_o == 0, "R6 reset counts", 80'({err_cnt_o, smp_cnt_o}), 80'(0));
    chk(es_rdata_o == 0 && es_sdata_o == 0, "R11 reset captures", es_rdata_o | es_sdata_o, 80'(0));

    // trigger table
    for (int v = 0; v < NV; v++) begin
      logic [37:0] e;
      e = VECS[v];
      ctrl_i = {e[37:34], 2'b10};
      step(1);
      chk_st($sformatf("R3 clear v%0d", v), S_CLEAR);
      step(1);
      chk_st($sformatf("R3 armed v%0d", v), S_ARMED);
      trig_i  = e[33];
      sdata_i = e[32:17];
      rdata_i = e[16:1];
      step(1);
      trig_i = 1'b0; sdata_i = '0; rdata_i = '0;
      if (e[0]) begin
        chk_st($sformatf("R10 fire v%0d", v), S_READ);
        chk(es_rdata_o == (80'(e[16:1]) << 24), $sformatf("R11 rcap v%0d", v), es_rdata_o, 80'(e[16:1]) << 24);
        chk(es_sdata_o == (80'(e[32:17]) << 24), $sformatf("R11 scap v%0d", v), es_sdata_o, 80'(e[32:17]) << 24);
        step(1);
        chk_st($sformatf("R12 read holds v%0d", v), S_READ);
        ctrl_i = '0;
      end else begin
        chk_st($sformatf("R7 no fire v%0d", v), S_ARMED);
        ctrl_i = '0;
        step(1);
        chk_st($sformatf("R10 arm drop v%0d", v), S_READ);
        chk(es_rdata_o == 0 && es_sdata_o == 0, $sformatf("R10 no capture v%0d", v), es_rdata_o | es_sdata_o, 80'(0));
      end
      step(1);
      chk_st($sformatf("R12 back idle v%0d", v), S_IDLE);
    end

    // previous and present slots
    ctrl_i = 6'b010010;
    step(2);
    rdata_i = 16'h1234; sdata_i = 16'h00F0;
    step(1);
    rdata_i = 16'hBEEF; sdata_i = 16'h0F00; trig_i = 1'b1;
    step(1);
    trig_i = 1'b0; rdata_i = '0; sdata_i = '0;
    chk_st("R9 external fire", S_READ);
    chk(es_rdata_o == ((80'(16'h1234) << 64) | (80'(16'hBEEF) << 24)), "R11 rdata slots",
        es_rdata_o, (80'(16'h1234) << 64) | (80'(16'hBEEF) << 24));
    chk(es_sdata_o == ((80'(16'h00F0) << 64) | (80'(16'h0F00) << 24)), "R11 sdata slots",
        es_sdata_o, (80'(16'h00F0) << 64) | (80'(16'h0F00) << 24));
    ctrl_i = '0;
    step(1);

    // abort clears stale captures
    ctrl_i = 6'b000110;
    step(2);
    chk_st("R3 armed abort", S_ARMED);
    ctrl_i = '0;
    step(1);
    chk_st("R10 abort read", S_READ);
    chk(es_rdata_o == 0 && es_sdata_o == 0, "R4 captures cleared", es_rdata_o | es_sdata_o, 80'(0));
    step(1);

    // BER window with 5 errors
    ctrl_i = 6'b000001;
    step(1);
    chk_st("R2 clear", S_CLEAR);
    step(1);
    chk_st("R2 count", S_COUNT);
    sdata_i = 16'h0002;
    step(5);
    chk(smp_cnt_o == 5 && err_cnt_o == 5, "R5 mid count", 80'({err_cnt_o, smp_cnt_o}), 80'({4'd5, 4'd5}));
    sdata_i = 16'h0001;
    step(9);
    chk_st("R5 last count cycle", S_COUNT);
    step(1);
    sdata_i = 16'h0002;
    chk_st("R5 end", S_END);
    chk(err_cnt_o == 5 && smp_cnt_o == 15, "R5 final counts", 80'({err_cnt_o, smp_cnt_o}), 80'({4'd5, 4'd15}));
    step(3);
    chk_st("R12 end holds", S_END);
    chk(err_cnt_o == 5 && smp_cnt_o == 15, "R6 end counts", 80'({err_cnt_o, smp_cnt_o}), 80'({4'd5, 4'd15}));
    ctrl_i = '0;
    step(2);
    chk_st("R12 idle", S_IDLE);
    chk(err_cnt_o == 5 && smp_cnt_o == 15, "R6 idle counts", 80'({err_cnt_o, smp_cnt_o}), 80'({4'd5, 4'd15}));

    // run and arm together, masked errors only
    sdata_i = 16'h0001;
    ctrl_i = 6'b000011;
    step(2);
    chk_st("R2 run wins", S_COUNT);
    chk(err_cnt_o == 0 && smp_cnt_o == 0, "R4 counts cleared", 80'({err_cnt_o, smp_cnt_o}), 80'(0));
    step(15);
    chk_st("R5 second end", S_END);
    chk(err_cnt_o == 0 && smp_cnt_o == 15, "R7 masked not counted", 80'({err_cnt_o, smp_cnt_o}), 80'({4'd0, 4'd15}));
    ctrl_i = 6'b000010;
    step(1);
    chk_st("R12 arm keeps end", S_END);
    ctrl_i = '0;
    step(1);
    chk_st("R12 final idle", S_IDLE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule